// File: doc/BRIEF.md
# Host-Target Mailbox Console

The block is a memory-mapped mailbox between a target processor and a host-side console/test harness. It holds two 64-bit registers: a request register written by the target and a response register that carries answers back. Both are reached as pairs of 32-bit words on a simple single-cycle register bus. A write is combinational on address, write-enable and data. A read is combinational from the address.

A request commits in two steps. The low word is accepted only into an empty request register. The high word then completes the command and launches it. The command word is decoded into a device byte, a command byte and a 48-bit payload. The block then does one of the following:
- emits a console byte;
- parks a single console read until a byte arrives on the RX input;
- raises a test-exit pulse with a code;
- flags an unknown request.

Every launched request empties the request register, which is the acknowledgement the target waits for.

Top module: `htm_mailbox`

## Requirements
- R1: A command word carries the device in bits 63:56, the command in bits 55:48 and the payload in bits 47:0. Device 0 is the system device and device 1 is the console.
- R2: A write to the request low word (byte offset 8) loads bits 31:0, clears bits 63:32 and sets a commit-allow flag, but only when the whole request register is zero. Otherwise the register keeps its value and the allow flag is cleared.
- R3: A write to the request high word (byte offset 12) is ignored unless the allow flag is set. When the flag is set, the write forms the command word from the written data and the stored low word, and launches that command.
- R4: Every launched command leaves the request register at zero from the next cycle.
- R5: Console command 1 gives a one-cycle tx_valid_o pulse in the cycle after the launch, carrying payload bits 7:0. The response becomes {device, command, 32'b0, 8'h01, byte}.
- R6: System command 0 with payload bit 0 set gives a one-cycle exit_valid_o pulse carrying payload bits 47:1. The response becomes {device, command, 48'b0}.
- R7: System command 0 with payload bit 0 clear raises no pulse. The response becomes {device, command, 48'b0}.
- R8: Console command 0 stores the request's upper 16 bits as the one pending read, replacing any older one, and leaves the response unchanged. A later RX byte loads the response with {pending device, pending command, 32'b0, 8'h01, byte} and retires the pending read.
- R9: An RX byte with no pending read has no effect on the response.
- R10: Any other device or command gives a one-cycle err_o pulse. The response becomes {device, command, 48'b0}. The three pulses are never high together.
- R11: A write to the response low word (offset 0) loads bits 31:0, clears bits 63:32 and sets rsp_partial_o. A write to the response high word (offset 4) loads bits 63:32 and clears rsp_partial_o.
- R12: Reads at offsets 0, 4, 8 and 12 return the response low, response high, request low and request high words. Any other address reads zero. After reset every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | AW | Byte address of the register word |
| bus_we_i | input | 1 | Write strobe for the addressed word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| rx_valid_i | input | 1 | Received console byte is valid |
| rx_byte_i | input | 8 | Received console byte |
| tx_valid_o | output | 1 | One-cycle console output pulse |
| tx_byte_o | output | 8 | Console output byte |
| exit_valid_o | output | 1 | One-cycle test exit pulse |
| exit_code_o | output | 47 | Exit code, zero means pass |
| err_o | output | 1 | One-cycle unknown request pulse |
| rsp_partial_o | output | 1 | Response register half written by the host |

## Verification
The bench builds the block with its default parameters: a 5-bit bus address, the response words at offsets 0 and 4, and the request words at 8 and 12. With 5 address bits, the unmapped addresses include both the unaligned offsets inside the map and a whole span above it, so the zero-read rule is exercised on both sides. The random mix draws devices and commands mostly from the small decoded set and sometimes from the full byte range. This brings every dispatch branch, repeated reads that overwrite one another, and RX bytes with and without a parked read within reach. Directed steps cover the rejected low write and the high write without permission, which together lock the request register until reset.

// File: rtl/htm_pkg.sv
package htm_pkg;
  localparam int WORD_W = 64;
  localparam int HALF_W = 32;
  localparam int DEV_W  = 8;
  localparam int CMD_W  = 8;
  localparam int TAG_W  = DEV_W + CMD_W;
  localparam int PAY_W  = WORD_W - TAG_W;
  localparam int CHAR_W = 8;
  localparam int CODE_W = PAY_W - 1;
  localparam int PAD_W  = WORD_W - TAG_W - CHAR_W - 1;

  localparam logic [DEV_W-1:0] DEV_SYS  = 8'd0;
  localparam logic [DEV_W-1:0] DEV_CON  = 8'd1;
  localparam logic [CMD_W-1:0] CMD_SYS  = 8'd0;
  localparam logic [CMD_W-1:0] CMD_GETC = 8'd0;
  localparam logic [CMD_W-1:0] CMD_PUTC = 8'd1;

  typedef enum logic [2:0] {
    ACT_IGNORE,
    ACT_EXIT,
    ACT_PUTC,
    ACT_GETC,
    ACT_BAD
  } act_e;

  typedef enum logic [1:0] {
    W_RSP_LO = 2'd0,
    W_RSP_HI = 2'd1,
    W_REQ_LO = 2'd2,
    W_REQ_HI = 2'd3
  } word_e;

  // tag above, optional 0x100-tagged character below
  function automatic logic [WORD_W-1:0] mk_rsp(input logic [TAG_W-1:0] tag,
                                               input logic ok,
                                               input logic [CHAR_W-1:0] ch);
    return {tag, {PAD_W{1'b0}}, ok, (ok ? ch : {CHAR_W{1'b0}})};
  endfunction
endpackage

// File: rtl/htm_addr_dec.sv
module htm_addr_dec
  import htm_pkg::*;
#(
  parameter int AW      = 5,
  parameter int RSP_OFF = 0,
  parameter int REQ_OFF = 8
) (
  input  logic [AW-1:0] addr_i,
  output logic [3:0]    sel_o
);
  localparam int HALF_BYTES = HALF_W / 8;

  for (genvar i = 0; i < 4; i++) begin : g_word
    localparam int BASE = (i < 2) ? RSP_OFF : REQ_OFF;
    localparam int OFF  = BASE + (i % 2) * HALF_BYTES;
    assign sel_o[i] = (addr_i == AW'(OFF));
  end
endmodule

// File: rtl/htm_dispatch.sv
module htm_dispatch
  import htm_pkg::*;
(
  input  logic [WORD_W-1:0] cmd_word_i,
  output act_e              act_o,
  output logic [CHAR_W-1:0] tx_byte_o,
  output logic [CODE_W-1:0] exit_code_o,
  output logic [WORD_W-1:0] rsp_o
);
  logic [DEV_W-1:0] dev;
  logic [CMD_W-1:0] cmd;
  logic [PAY_W-1:0] pay;

  assign dev = cmd_word_i[WORD_W-1 -: DEV_W];
  assign cmd = cmd_word_i[PAY_W +: CMD_W];
  assign pay = cmd_word_i[PAY_W-1:0];

  always_comb begin
    act_o = ACT_BAD;
    if (dev == DEV_SYS) begin
      if (cmd == CMD_SYS) act_o = pay[0] ? ACT_EXIT : ACT_IGNORE;
    end else if (dev == DEV_CON) begin
      if (cmd == CMD_GETC)      act_o = ACT_GETC;
      else if (cmd == CMD_PUTC) act_o = ACT_PUTC;
    end
  end

  assign tx_byte_o   = pay[CHAR_W-1:0];
  assign exit_code_o = pay[PAY_W-1:1];
  assign rsp_o       = mk_rsp(cmd_word_i[WORD_W-1 -: TAG_W], act_o == ACT_PUTC, pay[CHAR_W-1:0]);
endmodule

// File: rtl/htm_mailbox.sv
module htm_mailbox
  import htm_pkg::*;
#(
  parameter int AW      = 5,
  parameter int RSP_OFF = 0,
  parameter int REQ_OFF = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_byte_o,
  output logic              exit_valid_o,
  output logic [46:0]       exit_code_o,
  output logic              err_o,
  output logic              rsp_partial_o
);
  logic [3:0]        sel, wr;
  logic [WORD_W-1:0] req_q, rsp_q, merged, disp_rsp;
  logic [TAG_W-1:0]  pend_tag_q;
  logic              pend_v_q, allow_q, wip_q;
  logic              commit, rsp_busy;
  act_e              act;
  logic [CHAR_W-1:0] disp_byte;
  logic [CODE_W-1:0] disp_code;

  htm_addr_dec #(.AW(AW), .RSP_OFF(RSP_OFF), .REQ_OFF(REQ_OFF)) u_dec (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  assign wr     = sel & {4{bus_we_i}};
  assign commit = wr[W_REQ_HI] && allow_q;
  assign merged = {bus_wdata_i, req_q[HALF_W-1:0]};

  htm_dispatch u_disp (
    .cmd_word_i  (merged),
    .act_o       (act),
    .tx_byte_o   (disp_byte),
    .exit_code_o (disp_code),
    .rsp_o       (disp_rsp)
  );

  // host writes and command responses take the response register before RX
  assign rsp_busy = wr[W_RSP_LO] || wr[W_RSP_HI] || (commit && act != ACT_GETC);

  always_comb begin
    bus_rdata_o = '0;
    if (sel[W_RSP_LO])      bus_rdata_o = rsp_q[HALF_W-1:0];
    else if (sel[W_RSP_HI]) bus_rdata_o = rsp_q[WORD_W-1:HALF_W];
    else if (sel[W_REQ_LO]) bus_rdata_o = req_q[HALF_W-1:0];
    else if (sel[W_REQ_HI]) bus_rdata_o = req_q[WORD_W-1:HALF_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q        <= '0;
      rsp_q        <= '0;
      pend_tag_q   <= '0;
      pend_v_q     <= 1'b0;
      allow_q      <= 1'b0;
      wip_q        <= 1'b0;
      tx_valid_o   <= 1'b0;
      tx_byte_o    <= '0;
      exit_valid_o <= 1'b0;
      exit_code_o  <= '0;
      err_o        <= 1'b0;
    end else begin
      tx_valid_o   <= 1'b0;
      exit_valid_o <= 1'b0;
      err_o        <= 1'b0;

      if (wr[W_REQ_LO]) begin
        if (req_q == '0) begin
          req_q   <= {{HALF_W{1'b0}}, bus_wdata_i};
          allow_q <= 1'b1;
        end else begin
          allow_q <= 1'b0;
        end
      end

      if (rx_valid_i && pend_v_q && !rsp_busy) begin
        rsp_q    <= mk_rsp(pend_tag_q, 1'b1, rx_byte_i);
        pend_v_q <= 1'b0;
      end

      if (commit) begin
        req_q <= '0;
        unique case (act)
          ACT_PUTC: begin
            tx_valid_o <= 1'b1;
            tx_byte_o  <= disp_byte;
            rsp_q      <= disp_rsp;
          end
          ACT_EXIT: begin
            exit_valid_o <= 1'b1;
            exit_code_o  <= disp_code;
            rsp_q        <= disp_rsp;
          end
          ACT_GETC: begin
            pend_tag_q <= merged[WORD_W-1 -: TAG_W];
            pend_v_q   <= 1'b1;
          end
          ACT_BAD: begin
            err_o <= 1'b1;
            rsp_q <= disp_rsp;
          end
          default: rsp_q <= disp_rsp;
        endcase
      end

      if (wr[W_RSP_LO]) begin
        rsp_q <= {{HALF_W{1'b0}}, bus_wdata_i};
        wip_q <= 1'b1;
      end else if (wr[W_RSP_HI]) begin
        rsp_q[WORD_W-1:HALF_W] <= bus_wdata_i;
        wip_q                  <= 1'b0;
      end
    end
  end

  assign rsp_partial_o = wip_q;
endmodule

// File: rtl/htm_mailbox_chk.sv
module htm_mailbox_chk #(
  parameter int AW      = 5,
  parameter int RSP_OFF = 0,
  parameter int REQ_OFF = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] bus_addr_i,
  input logic          bus_we_i,
  input logic [31:0]   bus_rdata_o,
  input logic          tx_valid_o,
  input logic          exit_valid_o,
  input logic          err_o,
  input logic          rsp_partial_o,
  input logic [63:0]   req_q,
  input logic          allow_q
);
  logic at_rsp_lo, at_rsp_hi, at_req_lo, at_req_hi;
  assign at_rsp_lo = bus_addr_i == AW'(RSP_OFF);
  assign at_rsp_hi = bus_addr_i == AW'(RSP_OFF + 4);
  assign at_req_lo = bus_addr_i == AW'(REQ_OFF);
  assign at_req_hi = bus_addr_i == AW'(REQ_OFF + 4);

  assert_pulse_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_valid_o, exit_valid_o, err_o}));

  assert_tx_after_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(bus_we_i && at_req_hi));

  assert_exit_after_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_valid_o |-> $past(bus_we_i && at_req_hi));

  assert_low_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && at_req_lo && req_q != '0) |=> (req_q == $past(req_q) && !allow_q));

  assert_commit_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && at_req_hi && allow_q) |=> (req_q == '0));

  assert_partial_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && at_rsp_lo) |=> rsp_partial_o);

  assert_partial_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && at_rsp_hi) |=> !rsp_partial_o);

  assert_unmapped_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(at_rsp_lo || at_rsp_hi || at_req_lo || at_req_hi) |-> (bus_rdata_o == '0));
endmodule

bind htm_mailbox htm_mailbox_chk #(.AW(AW), .RSP_OFF(RSP_OFF), .REQ_OFF(REQ_OFF)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_addr_i    (bus_addr_i),
  .bus_we_i      (bus_we_i),
  .bus_rdata_o   (bus_rdata_o),
  .tx_valid_o    (tx_valid_o),
  .exit_valid_o  (exit_valid_o),
  .err_o         (err_o),
  .rsp_partial_o (rsp_partial_o),
  .req_q         (req_q),
  .allow_q       (allow_q)
);

// File: tb/htm_mailbox_bench.sv
module htm_mailbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam logic [AW-1:0] A_RSP_LO = 5'd0, A_RSP_HI = 5'd4, A_REQ_LO = 5'd8, A_REQ_HI = 5'd12;
  localparam int K_IGN = 0, K_EXIT = 1, K_PUTC = 2, K_GETC = 3, K_BAD = 4;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0, rdata;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = '0, tx_byte;
  logic          tx_valid, exit_valid, err, partial;
  logic [46:0]   exit_code;

  htm_mailbox u_htm_mailbox (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .rx_valid_i(rx_valid),
    .rx_byte_i(rx_byte), .tx_valid_o(tx_valid), .tx_byte_o(tx_byte),
    .exit_valid_o(exit_valid), .exit_code_o(exit_code), .err_o(err),
    .rsp_partial_o(partial)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [63:0] m_req, m_rsp;
  logic [15:0] m_pend;
  bit m_pend_v, m_allow, m_wip;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R1: device 63:56, command 55:48, payload 47:0
  function automatic int kind_of(input logic [63:0] w);
    if (w[63:56] == 8'd0) return (w[55:48] == 8'd0) ? (w[0] ? K_EXIT : K_IGN) : K_BAD;
    if (w[63:56] == 8'd1) return (w[55:48] == 8'd0) ? K_GETC : ((w[55:48] == 8'd1) ? K_PUTC : K_BAD);
    return K_BAD;
  endfunction

  function automatic logic [63:0] rsp_of(input logic [15:0] tag, input bit ok, input logic [7:0] ch);
    return {tag, 39'b0, ok, ok ? ch : 8'h00};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; we = 1'b0; rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_req = '0; m_rsp = '0; m_pend = '0; m_pend_v = 0; m_allow = 0; m_wip = 0;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    logic [2:0]  ep = 3'b000;
    logic [7:0]  eb = '0;
    logic [46:0] ec = '0;
    logic [63:0] m = '0;
    int k = -1;
    string tag = "R2 pulses";
    if (a == A_REQ_HI) begin
      tag = "R3 no launch";
      if (m_allow) begin
        m = {d, m_req[31:0]};
        k = kind_of(m);
        case (k)
          K_PUTC: begin ep = 3'b100; eb = m[7:0]; tag = "R1/R5 putc"; end
          K_EXIT: begin ep = 3'b010; ec = m[47:1]; tag = "R6 exit"; end
          K_IGN:  tag = "R7 ignored syscall";
          K_GETC: tag = "R8 getc";
          default: begin ep = 3'b001; tag = "R10 unknown"; end
        endcase
      end
    end
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
    chk(tag, {61'b0, tx_valid, exit_valid, err}, {61'b0, ep});
    if (ep[2]) chk("R5 tx byte", {56'b0, tx_byte}, {56'b0, eb});
    if (ep[1]) chk("R6 exit code", {17'b0, exit_code}, {17'b0, ec});
    case (a)
      A_REQ_LO: if (m_req == '0) begin m_req = {32'b0, d}; m_allow = 1; end else m_allow = 0;
      A_REQ_HI: if (m_allow) begin
        m_req = '0;
        if (k == K_GETC) begin m_pend = m[63:48]; m_pend_v = 1; end
        else m_rsp = rsp_of(m[63:48], k == K_PUTC, m[7:0]);
      end
      A_RSP_LO: begin m_rsp = {32'b0, d}; m_wip = 1; end
      A_RSP_HI: begin m_rsp[63:32] = d; m_wip = 0; end
      default: ;
    endcase
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
    chk("R9 rx no pulse", {61'b0, tx_valid, exit_valid, err}, 64'd0);
    if (m_pend_v) begin m_rsp = rsp_of(m_pend, 1, b); m_pend_v = 0; end
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a;
    #1 chk(tag, {32'b0, rdata}, {32'b0, exp});
  endtask

  task automatic check_all();
    read_chk(A_RSP_LO, m_rsp[31:0], "R12 rsp lo");
    read_chk(A_RSP_HI, m_rsp[63:32], "R12 rsp hi");
    read_chk(A_REQ_LO, m_req[31:0], "R4 req lo");
    read_chk(A_REQ_HI, m_req[63:32], "R4 req hi");
    chk("R11 partial", {63'b0, partial}, {63'b0, m_wip});
  endtask

  task automatic send_cmd(input logic [63:0] w);
    bus_write(A_REQ_LO, w[31:0]);
    bus_write(A_REQ_HI, w[63:32]);
  endtask

  function automatic logic [7:0] pick_small();
    int r = $urandom_range(0, 9);
    if (r < 4) return 8'd0;
    if (r < 8) return 8'd1;
    return 8'($urandom);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    do_reset();
    check_all();
    read_chk(5'd2, 32'h0, "R12 unmapped");
    read_chk(5'd20, 32'h0, "R12 unmapped");
    // R3: high write with no prior low write
    bus_write(A_REQ_HI, 32'h0101_0000);
    check_all();
    // R5 putc 'A'
    send_cmd(64'h0101_0000_0000_0041);
    check_all();
    chk("R5 rsp", m_rsp, 64'h0101_0000_0000_0141);
    // R6 exit code 5
    send_cmd(64'h0000_0000_0000_000B);
    check_all();
    // R7 even payload
    send_cmd(64'h0000_0000_0000_1000);
    check_all();
    // R9 rx with nothing pending
    rx_send(8'h33);
    check_all();
    // R8 getc then rx
    send_cmd(64'h0100_0000_0000_0000);
    check_all();
    rx_send(8'h5A);
    check_all();
    chk("R8 rsp", m_rsp, 64'h0100_0000_0000_015A);
    // R10 unknown device and unknown console command
    send_cmd(64'h0300_0000_0000_0077);
    check_all();
    send_cmd(64'h0107_0000_0000_0077);
    check_all();
    // R11 host side halves
    bus_write(A_RSP_LO, 32'hdead_beef);
    check_all();
    bus_write(A_RSP_HI, 32'h1234_5678);
    check_all();
    // R2 rejection locks the request register
    do_reset();
    bus_write(A_REQ_LO, 32'h0000_0041);
    bus_write(A_REQ_LO, 32'h0000_0099);
    check_all();
    bus_write(A_REQ_HI, 32'h0101_0000);
    check_all();
    do_reset();
    check_all();

    for (int i = 0; i < 500; i++) begin
      int op = $urandom_range(0, 99);
      if (op < 65) begin
        logic [63:0] w = {pick_small(), pick_small(), 16'($urandom), 32'($urandom)};
        if ($urandom_range(0, 1) == 0) w[0] = 1'b1;
        send_cmd(w);
      end else if (op < 75) bus_write(A_RSP_LO, $urandom);
      else if (op < 83) bus_write(A_RSP_HI, $urandom);
      else if (op < 95) rx_send(8'($urandom));
      else bus_write(A_REQ_HI, $urandom);
      check_all();
      if (op % 7 == 0) read_chk(AW'($urandom_range(13, 31)), 32'h0, "R12 unmapped");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule